// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM alive for the access sequencer that shares the strobes with it. Once reset is released it sits out a timed power-up pause. It then runs a fixed number of CAS-before-RAS (CBR) cycles, one after another, before it declares the memory ready. After that it converts the refresh period into a row interval: the whole period divided by the number of rows, rounded up to whole clock cycles. Each time that interval ends, one refresh becomes pending. The block asks the sequencer for the bus and, once granted, spends the pending refresh on a CBR cycle. The row address comes from the counter inside the DRAM, so the block drives only RAS, the two byte CAS strobes and WE.

All timing is given in nanoseconds and converted to cycles of a clock whose period is a parameter. A sleep request makes the next granted cycle a self-refresh entry. RAS and both CAS strobes stay low for as long as sleep is requested, and never for less than the minimum self-refresh pulse. On exit the block waits out the long self-refresh precharge. It then runs exactly one catch-up CBR cycle before it hands the bus back. A sticky error flag reports that the sequencer withheld the grant long enough for the pending count to saturate.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, req, drv_en and init_done are 0. ref_ovf and sleep_ack are also 0, and ras_n, cas_lo_n, cas_hi_n and we_n are all 1.
- R2: After reset, req stays 0 for ceil(PAUSE_NS*1000/CLK_PS) cycles and then rises.
- R3: In response to the first grant the block runs INIT_CBR CBR cycles back to back without dropping req. In the cycle after the last precharge, init_done rises, req falls, and init_done stays 1 from then on.
- R4: cas_lo_n and cas_hi_n are always equal. In each refresh cycle CAS goes low ceil(CSR_NS) cycles before RAS falls. In a normal CBR cycle CAS stays low for ceil(CHR_NS) cycles after RAS falls.
- R5: A normal CBR cycle holds ras_n low for ceil(RAS_NS) cycles. we_n is 1 whenever drv_en is 1. When drv_en is 0, all four strobes are 1.
- R6: After RAS rises at the end of a normal CBR cycle, drv_en stays 1 with RAS and CAS high for ceil(RP_NS) cycles. Only then is the bus released, or the next CAS setup begun.
- R7: Once init_done is 1, one refresh becomes pending every ceil((REF_NS/ROWS)*1000/CLK_PS) cycles. Each pending refresh is spent on its own CBR cycle, so with the grant held high, consecutive refreshes start exactly that many cycles apart.
- R8: At most PEND_MAX refreshes can be pending. If an interval ends while PEND_MAX are already pending, ref_ovf is set, and it stays set until reset.
- R9: If sleep_req is 1 when a request is granted after init_done, a self-refresh cycle is run: CAS goes low, RAS falls, sleep_ack is 1, and RAS and CAS stay low. The low time lasts as long as sleep_req is held, and at least ceil(RASS_NS) cycles even if sleep_req drops sooner.
- R10: When self refresh ends, RAS and CAS stay high for ceil(RPS_NS) cycles. Exactly one CBR cycle then follows under the same grant, after which req drops. No intervals are counted and no pending refreshes are kept while self refresh is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_PS picoseconds |
| rst | input | 1 | Synchronous active-high reset |
| gnt | input | 1 | Bus grant from the access sequencer, sampled while waiting |
| sleep_req | input | 1 | Request to enter self refresh and stay in it |
| req | output | 1 | Bus request to the access sequencer, held until the work is done |
| drv_en | output | 1 | High while this block owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Power-up sequence complete, normal accesses allowed |
| sleep_ack | output | 1 | Self refresh in progress |
| ref_ovf | output | 1 | Sticky: a refresh interval ended with the pending count full |

## Verification
The bench uses a 5 ns clock with a 200 ns pause (40 cycles), four rows in a 2000 ns refresh period (a 100-cycle interval) and a 500 ns minimum self-refresh pulse (100 cycles). The stroke timings keep their default values of 2, 2, 10 and 7 cycles. With these values, the whole power-up sequence, several refresh intervals, saturation of the pending count at three and a full self-refresh round trip all fit in a couple of thousand cycles. Every RAS edge is measured against the arithmetic expectations, and grant withholding windows are placed between known interval boundaries, so the number of back-to-back refreshes is exact.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_WAIT,
        ST_CAS_SU,
        ST_RAS_LO,
        ST_PRE,
        ST_SELF,
        ST_SELF_PRE
    } ref_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // round a time in ns up to whole clock cycles, never below one
    function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                              input int unsigned clk_ps);
        longint unsigned c;
        c = (ns * 64'd1000 + longint'(clk_ps) - 64'd1) / longint'(clk_ps);
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_interval.sv
module dref_interval
    import dram_ref_pkg::*;
#(
    parameter int TICK_C   = 6250,
    parameter int PEND_MAX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic dec,
    input  logic clr,
    output logic pend_nz,
    output logic ovf
);
    localparam int TW = $clog2(TICK_C + 1);
    localparam int PW = $clog2(PEND_MAX + 1);

    logic [TW-1:0] tcnt;
    logic [PW-1:0] pend;
    logic          tick;

    assign tick = run && (tcnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) tcnt <= TW'(TICK_C - 1);
        else                     tcnt <= tcnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ovf  <= 1'b0;
        end else if (clr) begin
            pend <= '0;
        end else begin
            case ({tick, dec})
                2'b10: begin
                    if (pend == PW'(PEND_MAX)) ovf <= 1'b1;
                    else                       pend <= pend + 1'b1;
                end
                2'b01: if (pend != '0) pend <= pend - 1'b1;
                default: ;
            endcase
        end
    end

    assign pend_nz = (pend != '0);

endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dram_ref_pkg::*;
#(
    parameter int PAUSE_C  = 40000,
    parameter int INIT_CBR = 8,
    parameter int CSR_C    = 2,
    parameter int CHR_C    = 2,
    parameter int RAS_C    = 10,
    parameter int RP_C     = 7,
    parameter int RASS_C   = 20000,
    parameter int RPS_C    = 22
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       gnt,
    input  logic       sleep_ok,
    input  logic       pend_nz,
    output ref_state_e st,
    output logic       cas_hold,
    output logic       dec,
    output logic       clr,
    output logic       run,
    output logic       done
);
    localparam int CW = $clog2(max2(max2(max2(PAUSE_C, RASS_C), max2(RAS_C, RP_C)),
                                    max2(max2(CSR_C, CHR_C), RPS_C)) + 1);
    localparam int IW = $clog2(INIT_CBR + 1);

    logic [CW-1:0] cnt;
    logic [IW-1:0] init_n;
    logic          self_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_PAUSE;
            cnt    <= '0;
            init_n <= '0;
            done   <= 1'b0;
            self_m <= 1'b0;
        end else begin
            case (st)
                ST_PAUSE: begin
                    if (cnt == CW'(PAUSE_C - 1)) begin
                        cnt <= '0;
                        st  <= ST_WAIT;
                    end else cnt <= cnt + 1'b1;
                end
                ST_IDLE: if (pend_nz || sleep_ok) st <= ST_WAIT;
                ST_WAIT: begin
                    if (gnt) begin
                        st     <= ST_CAS_SU;
                        cnt    <= '0;
                        self_m <= done && sleep_ok;
                    end
                end
                ST_CAS_SU: begin
                    if (cnt == CW'(CSR_C - 1)) begin
                        cnt <= '0;
                        st  <= self_m ? ST_SELF : ST_RAS_LO;
                    end else cnt <= cnt + 1'b1;
                end
                ST_RAS_LO: begin
                    if (cnt == CW'(RAS_C - 1)) begin
                        cnt <= '0;
                        st  <= ST_PRE;
                    end else cnt <= cnt + 1'b1;
                end
                ST_PRE: begin
                    if (cnt == CW'(RP_C - 1)) begin
                        cnt <= '0;
                        if (!done) begin
                            if (init_n == IW'(INIT_CBR - 1)) begin
                                done <= 1'b1;
                                st   <= ST_IDLE;
                            end else begin
                                init_n <= init_n + 1'b1;
                                st     <= ST_CAS_SU;
                            end
                        end else st <= ST_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
                ST_SELF: begin
                    if (cnt == CW'(RASS_C - 1)) begin
                        if (!sleep_ok) begin
                            cnt    <= '0;
                            self_m <= 1'b0;
                            st     <= ST_SELF_PRE;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                ST_SELF_PRE: begin
                    if (cnt == CW'(RPS_C - 1)) begin
                        cnt <= '0;
                        st  <= ST_CAS_SU;
                    end else cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cas_hold = (st == ST_RAS_LO) && (cnt < CW'(CHR_C));
    assign dec      = (st == ST_RAS_LO) && (cnt == CW'(RAS_C - 1)) && done;
    assign clr      = (st == ST_CAS_SU) && (cnt == CW'(CSR_C - 1)) && self_m;
    assign run      = done && !self_m && (st != ST_SELF) && (st != ST_SELF_PRE);

endmodule

// File: rtl/dref_strobe.sv
module dref_strobe
    import dram_ref_pkg::*;
(
    input  ref_state_e st,
    input  logic       cas_hold,
    output strobe_t    strb
);
    always_comb begin
        strb = STROBE_IDLE;
        case (st)
            ST_CAS_SU: begin
                strb.cas_n = 1'b0;
                strb.drive = 1'b1;
            end
            ST_RAS_LO: begin
                strb.ras_n = 1'b0;
                strb.cas_n = !cas_hold;
                strb.drive = 1'b1;
            end
            ST_SELF: begin
                strb.ras_n = 1'b0;
                strb.cas_n = 1'b0;
                strb.drive = 1'b1;
            end
            ST_PRE, ST_SELF_PRE: strb.drive = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int CLK_PS   = 5000,
    parameter int PAUSE_NS = 200000,
    parameter int REF_NS   = 16000000,
    parameter int ROWS     = 512,
    parameter int INIT_CBR = 8,
    parameter int PEND_MAX = 3,
    parameter int CSR_NS   = 10,
    parameter int CHR_NS   = 10,
    parameter int RAS_NS   = 50,
    parameter int RP_NS    = 35,
    parameter int RASS_NS  = 100000,
    parameter int RPS_NS   = 110,
    parameter bit SELF_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic gnt,
    input  logic sleep_req,
    output logic req,
    output logic drv_en,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic we_n,
    output logic init_done,
    output logic sleep_ack,
    output logic ref_ovf
);
    localparam int PAUSE_C = ns_to_cyc(PAUSE_NS, CLK_PS);
    localparam int TICK_C  = ns_to_cyc(REF_NS / ROWS, CLK_PS);
    localparam int CSR_C   = ns_to_cyc(CSR_NS, CLK_PS);
    localparam int CHR_C   = ns_to_cyc(CHR_NS, CLK_PS);
    localparam int RAS_C   = ns_to_cyc(RAS_NS, CLK_PS);
    localparam int RP_C    = ns_to_cyc(RP_NS, CLK_PS);
    localparam int RASS_C  = ns_to_cyc(RASS_NS, CLK_PS);
    localparam int RPS_C   = ns_to_cyc(RPS_NS, CLK_PS);

    ref_state_e st;
    strobe_t    strb;
    logic       sleep_ok, cas_hold, dec, clr, run, pend_nz;

    generate
        if (SELF_EN) begin : g_self
            assign sleep_ok = sleep_req;
        end else begin : g_noself
            assign sleep_ok = 1'b0;
        end
    endgenerate

    dref_seq #(
        .PAUSE_C(PAUSE_C), .INIT_CBR(INIT_CBR), .CSR_C(CSR_C), .CHR_C(CHR_C),
        .RAS_C(RAS_C), .RP_C(RP_C), .RASS_C(RASS_C), .RPS_C(RPS_C)
    ) u_seq (
        .clk(clk), .rst(rst), .gnt(gnt), .sleep_ok(sleep_ok), .pend_nz(pend_nz),
        .st(st), .cas_hold(cas_hold), .dec(dec), .clr(clr), .run(run), .done(init_done)
    );

    dref_interval #(
        .TICK_C(TICK_C), .PEND_MAX(PEND_MAX)
    ) u_ivl (
        .clk(clk), .rst(rst), .run(run), .dec(dec), .clr(clr),
        .pend_nz(pend_nz), .ovf(ref_ovf)
    );

    dref_strobe u_strb (
        .st(st), .cas_hold(cas_hold), .strb(strb)
    );

    assign req       = (st != ST_PAUSE) && (st != ST_IDLE);
    assign drv_en    = strb.drive;
    assign ras_n     = strb.ras_n;
    assign cas_lo_n  = strb.cas_n;
    assign cas_hi_n  = strb.cas_n;
    assign we_n      = strb.we_n;
    assign sleep_ack = (st == ST_SELF);

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int PAUSE_C = 40000
) (
    input logic clk,
    input logic rst,
    input logic req,
    input logic drv_en,
    input logic ras_n,
    input logic cas_lo_n,
    input logic cas_hi_n,
    input logic we_n,
    input logic init_done,
    input logic sleep_ack,
    input logic ref_ovf
);
    int unsigned since_rst;

    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= 0;
        else if (since_rst < PAUSE_C) since_rst <= since_rst + 1;
    end

    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst < PAUSE_C) |-> !req);

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_cas_pair_r4: assert property (@(posedge clk) disable iff (rst)
        cas_lo_n == cas_hi_n);

    p_cas_first_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_lo_n && $past(!cas_lo_n)));

    p_we_high_r5: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> we_n);

    p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (ras_n && cas_lo_n && cas_hi_n && we_n));

    p_drive_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> req);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        ref_ovf |=> ref_ovf);

    p_sleep_low_r9: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> (!ras_n && !cas_lo_n && init_done));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.PAUSE_C(PAUSE_C)) u_chk (
    .clk(clk), .rst(rst), .req(req), .drv_en(drv_en), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n),
    .init_done(init_done), .sleep_ack(sleep_ack), .ref_ovf(ref_ovf)
);

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
    localparam int CLK_PS   = 5000;
    localparam int PAUSE_NS = 200;
    localparam int REF_NS   = 2000;
    localparam int ROWS     = 4;
    localparam int RASS_NS  = 500;
    localparam int INIT_CBR = 8;
    localparam int PEND_MAX = 3;

    localparam int PAUSE_C = (PAUSE_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int TICK_C  = ((REF_NS / ROWS) * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int CSR_C   = (10 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int CHR_C   = (10 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RAS_C   = (50 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RP_C    = (35 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RASS_C  = (RASS_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RPS_C   = (110 * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b1;
    logic sleep_req = 1'b0;
    logic req, drv_en, ras_n, cas_lo_n, cas_hi_n, we_n, init_done, sleep_ack, ref_ovf;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .CLK_PS(CLK_PS), .PAUSE_NS(PAUSE_NS), .REF_NS(REF_NS), .ROWS(ROWS),
        .INIT_CBR(INIT_CBR), .PEND_MAX(PEND_MAX), .RASS_NS(RASS_NS)
    ) u_dut (
        .clk(clk), .rst(rst), .gnt(gnt), .sleep_req(sleep_req), .req(req),
        .drv_en(drv_en), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
        .we_n(we_n), .init_done(init_done), .sleep_ack(sleep_ack), .ref_ovf(ref_ovf)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor state, updated at every falling clock edge
    int  cyc = 0;
    int  creq = -1;
    int  n_fall = 0;
    int  last_fall = 0;
    int  casrun = 0, lowlen = 0, lowcas = 0, gap = 0, postdrv = 0;
    int  self_len = 0;
    bit  self_seen = 0, after_self = 0, in_post = 0;
    bit  prev_ras = 1'b1;
    bit  we_bad = 0, pair_bad = 0, idle_bad = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (req && creq < 0) creq = cyc;
            if (drv_en && !we_n) we_bad = 1;
            if (cas_lo_n != cas_hi_n) pair_bad = 1;
            if (!drv_en && !(ras_n && cas_lo_n && we_n)) idle_bad = 1;
            if (prev_ras && !ras_n) begin
                n_fall++;
                last_fall = cyc;
                check(casrun == CSR_C, "R4 cas setup", casrun, CSR_C);
                if (after_self) check(gap == RPS_C + CSR_C, "R10 exit gap", gap, RPS_C + CSR_C);
                else if (n_fall > 1) check(gap >= RP_C + CSR_C, "R6 gap", gap, RP_C + CSR_C);
                lowlen = 0; lowcas = 0; in_post = 0;
            end
            if (!ras_n) begin
                lowlen++;
                if (!cas_lo_n) lowcas++;
            end else if (!prev_ras) begin
                if (lowcas == lowlen) begin
                    self_len = lowlen; self_seen = 1; after_self = 1;
                end else begin
                    check(lowlen == RAS_C, "R5 ras width", lowlen, RAS_C);
                    check(lowcas == CHR_C, "R4 cas hold", lowcas, CHR_C);
                    after_self = 0;
                end
                gap = 1; postdrv = 0; in_post = !after_self;
            end else gap++;
            if (ras_n) casrun = cas_lo_n ? 0 : casrun + 1;
            if (in_post && ras_n) begin
                if (drv_en) postdrv++;
                else begin
                    check(postdrv == RP_C, "R6 precharge", postdrv, RP_C);
                    in_post = 0;
                end
            end
            prev_ras = ras_n;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic until_cyc(input int c);
        while (cyc < c) step();
    endtask

    task automatic wait_fall(output int at);
        int n0 = n_fall;
        while (n_fall == n0) step();
        at = last_fall;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 5);
        check(0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        int c0, f1, f2, c, c2, n0, n_ack, wd;
        repeat (3) step();
        // R1 reset state
        check(!req && !drv_en && !init_done && !ref_ovf && !sleep_ack, "R1 ctl", req, 0);
        check(ras_n && cas_lo_n && cas_hi_n && we_n, "R1 strobes", ras_n, 1);
        rst = 1'b0;
        c0 = cyc;
        step();
        check(!req && ras_n && !init_done, "R1 after release", req, 0);

        // R2 / R3 power-up
        wd = 0;
        while (!init_done && wd < 2000) begin step(); wd++; end
        check(creq - c0 == PAUSE_C, "R2 pause", creq - c0, PAUSE_C);
        check(n_fall == INIT_CBR, "R3 init cycles", n_fall, INIT_CBR);
        check(!req, "R3 req drop", req, 0);

        // R7 periodic spacing
        wait_fall(f1);
        wait_fall(f2);
        check(f2 - f1 == TICK_C, "R7 spacing", f2 - f1, TICK_C);

        // R7 pending refreshes kept while grant withheld
        wait_fall(c);
        gnt = 1'b0;
        n0 = n_fall;
        until_cyc(c + TICK_C * 2 + 20);
        check(n_fall == n0, "R7 no grant no cycle", n_fall - n0, 0);
        gnt = 1'b1;
        until_cyc(c + TICK_C * 3 - 10);
        check(n_fall - n0 == 2, "R7 pending burst", n_fall - n0, 2);

        // R8 saturation and sticky overflow
        wait_fall(c2);
        gnt = 1'b0;
        n0 = n_fall;
        until_cyc(c2 + TICK_C * 4 - 10);
        check(!ref_ovf, "R8 no ovf at full", ref_ovf, 0);
        until_cyc(c2 + TICK_C * 4);
        check(ref_ovf, "R8 ovf set", ref_ovf, 1);
        until_cyc(c2 + TICK_C * 4 + 10);
        gnt = 1'b1;
        until_cyc(c2 + TICK_C * 5 - 10);
        check(n_fall - n0 == PEND_MAX, "R8 saturated burst", n_fall - n0, PEND_MAX);
        check(ref_ovf, "R8 ovf sticky", ref_ovf, 1);

        // R9 / R10 self refresh round trip
        wait_fall(c);
        until_cyc(c + 30);
        sleep_req = 1'b1;
        wd = 0;
        while (!sleep_ack && wd < 100) begin step(); wd++; end
        check(sleep_ack, "R9 ack", sleep_ack, 1);
        n_ack = n_fall;
        repeat (30) step();
        check(sleep_ack && !ras_n, "R9 held low", ras_n, 0);
        sleep_req = 1'b0;
        wd = 0;
        while (req && wd < 400) begin step(); wd++; end
        check(self_seen, "R9 cas low throughout", self_seen, 1);
        check(self_len == RASS_C, "R9 min pulse", self_len, RASS_C);
        check(n_fall - n_ack == 1, "R10 one catch-up", n_fall - n_ack, 1);
        check(!sleep_ack, "R10 ack clear", sleep_ack, 0);
        repeat (20) step();
        check(n_fall - n_ack == 1, "R10 no extra cycle", n_fall - n_ack, 1);

        check(!we_bad, "R5 we high", we_bad, 0);
        check(!idle_bad, "R5 idle strobes", idle_bad, 0);
        check(!pair_bad, "R4 cas pair", pair_bad, 0);
        check(init_done, "R3 done sticky", init_done, 1);
        summary();
    end
endmodule